// File: doc/BRIEF.md
# Debug View and Register Window Bus Wrapper

This block sits between a small accumulator-style CPU core and the chip pins. It does two things on the address path. First, while a configuration pin enables it, it claims a window of eight byte addresses at the top of the low half of the address space, 0x78 through 0x7F. Those addresses are served by eight local 8-bit scratch registers instead of external memory. Second, a 3-bit debug selector picks the value driven onto the seven address pins. That value is either the core's bus address or one of the core's internal values.

Core accesses to the window never reach the pins as writes. A write lands in the addressed scratch register on the clock edge, and the external write strobe stays low. A read returns the scratch register's contents in the same cycle in which an external read would return pin data. Two further configuration bits pass straight to the core: one enables the demo program and one requests a halt at the next fetch.

The core bus here is a plain single-cycle strobe interface with no back-pressure. Every access completes in the cycle it is presented, so no valid/ready handshake is used.

Top module: `dbg_regwin_wrap`

## Requirements
- R1: After reset, all eight scratch registers read 0x00 through the window.
- R2: With the window enabled (`test_cfg[7]` = 1), a core write to address 0x78+k updates scratch register k at the next rising clock edge. Later reads of 0x78+k return that value.
- R3: A write that hits the window keeps the pin write strobe `pin_out[7]` at 0. A write outside the window drives `pin_out[7]` to 1 in the same cycle, and `pin_data_out` carries the write data.
- R4: A read that hits the window returns the scratch register on `core_rdata` in the same cycle, with no added latency. A read outside the window returns `pin_data_in` unchanged.
- R5: With the window disabled (`test_cfg[7]` = 0), addresses 0x78 to 0x7F behave as external: writes strobe the pin and leave the scratch registers untouched, and reads return pin data.
- R6: Addresses whose upper five bits differ from 0b01111 never hit the window, including 0x77 and 0xF8 to 0xFF.
- R7: Debug select `test_cfg[2:0]` = 000 drives `core_addr[6:0]` onto `pin_out[6:0]`.
- R8: Select 001 drives accumulator bits 6:0. Select 010 drives accumulator bit 7 on `pin_out[0]`, with `pin_out[6:1]` = 0.
- R9: Select 011 shows M[6:0], 100 shows PC[6:0], 101 shows IR[6:0], 110 shows CCR[1:0] on `pin_out[1:0]` with zeros above, and 111 shows the control-unit state[6:0].
- R10: `test_cfg[4]` drives `demo_rom_en` and `test_cfg[3]` drives `halt_req`. `test_cfg[6:5]` change no output.
- R11: `pin_out[7]` follows the external write strobe whatever the debug select is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_cfg | input | 8 | Configuration pins: window enable, demo enable, halt request, debug select |
| core_addr | input | 8 | Core bus address |
| core_wdata | input | 8 | Core write data |
| core_we | input | 1 | Core write strobe |
| core_rdata | output | 8 | Read data returned to the core |
| dbg_acc | input | 8 | Core accumulator |
| dbg_mptr | input | 7 | Core memory pointer, low bits |
| dbg_pc | input | 7 | Core program counter, low bits |
| dbg_ir | input | 7 | Core instruction register, low bits |
| dbg_ccr | input | 2 | Core condition flags |
| dbg_cu_state | input | 7 | Core control-unit state |
| halt_req | output | 1 | Halt request to the core |
| demo_rom_en | output | 1 | Demo program enable to the core |
| pin_out | output | 8 | Bit 7 is the write strobe; bits 6:0 carry the address or debug view |
| pin_data_in | input | 8 | External read data |
| pin_data_out | output | 8 | External write data |
| pin_data_oe | output | 1 | Output enable for the data pins |

## Verification
The bench builds the block with its default parameters: eight registers, a window base of 0x78, 8-bit data and address, and seven address pins. With these values the window's edges (0x77, 0x78, 0x7F, 0xF8) and the single-bit and two-bit debug views can be reached directly. Every debug select code is walked against two sets of internal values. Each register then goes through a full write and read-back, and window-disabled aliasing checks that the registers keep their contents.

// File: rtl/dbg_regwin_pkg.sv
package dbg_regwin_pkg;

  typedef enum logic [2:0] {
    VIEW_ADDR  = 3'd0,
    VIEW_ACC   = 3'd1,
    VIEW_ACC7  = 3'd2,
    VIEW_MPTR  = 3'd3,
    VIEW_PC    = 3'd4,
    VIEW_IR    = 3'd5,
    VIEW_CCR   = 3'd6,
    VIEW_STATE = 3'd7
  } view_sel_e;

  localparam int CFG_WIN_EN_BIT = 7;
  localparam int CFG_DEMO_BIT   = 4;
  localparam int CFG_HALT_BIT   = 3;

endpackage

// File: rtl/regwin_bank.sv
module regwin_bank #(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int REG_COUNT = 8,
  parameter logic [7:0] WIN_BASE = 8'h78
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  output logic              hit,
  output logic [DATA_W-1:0] rd_val
);
  localparam int IDX_W = $clog2(REG_COUNT);
  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(WIN_BASE);

  logic [REG_COUNT-1:0][DATA_W-1:0] regs_q;
  logic [IDX_W-1:0] idx;

  assign idx = addr[IDX_W-1:0];
  assign hit = win_en && (addr[ADDR_W-1:IDX_W] == BASE[ADDR_W-1:IDX_W]);
  assign rd_val = regs_q[idx];

  for (genvar k = 0; k < REG_COUNT; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_q[k] <= '0;
      else if (hit && we && (idx == IDX_W'(k)))
        regs_q[k] <= wdata;
    end
  end

  // R1: registers are clear when reset releases
  a_r1_clear_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (regs_q == '0));

  // R2: a window write lands in the addressed register
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && we) |=> (regs_q[$past(idx)] == $past(wdata)));

  // R5: with the window off the bank holds its contents
  a_r5_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |=> $stable(regs_q));

endmodule

// File: rtl/dbg_view_mux.sv
module dbg_view_mux
  import dbg_regwin_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PIN_W  = 7
) (
  input  view_sel_e         sel,
  input  logic [PIN_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0] acc,
  input  logic [PIN_W-1:0]  mptr,
  input  logic [PIN_W-1:0]  pc,
  input  logic [PIN_W-1:0]  ir,
  input  logic [1:0]        ccr,
  input  logic [PIN_W-1:0]  cu_state,
  output logic [PIN_W-1:0]  view
);
  localparam int CCR_PAD = PIN_W - 2;
  localparam int MSB_PAD = PIN_W - 1;

  always_comb begin
    unique case (sel)
      VIEW_ADDR:  view = bus_addr;
      VIEW_ACC:   view = acc[PIN_W-1:0];
      VIEW_ACC7:  view = {{MSB_PAD{1'b0}}, acc[DATA_W-1]};
      VIEW_MPTR:  view = mptr;
      VIEW_PC:    view = pc;
      VIEW_IR:    view = ir;
      VIEW_CCR:   view = {{CCR_PAD{1'b0}}, ccr};
      default:    view = cu_state;
    endcase
  end

  // R8: the single-bit view keeps upper pins low
  always_comb begin
    if (sel == VIEW_ACC7)
      a_r8_acc7_upper_zero: assert (view[PIN_W-1:1] == '0);
  end

endmodule

// File: rtl/dbg_regwin_wrap.sv
module dbg_regwin_wrap
  import dbg_regwin_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int PIN_W     = 7,
  parameter int REG_COUNT = 8,
  parameter logic [7:0] WIN_BASE = 8'h78
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        test_cfg,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic [DATA_W-1:0] core_wdata,
  input  logic              core_we,
  output logic [DATA_W-1:0] core_rdata,
  input  logic [DATA_W-1:0] dbg_acc,
  input  logic [PIN_W-1:0]  dbg_mptr,
  input  logic [PIN_W-1:0]  dbg_pc,
  input  logic [PIN_W-1:0]  dbg_ir,
  input  logic [1:0]        dbg_ccr,
  input  logic [PIN_W-1:0]  dbg_cu_state,
  output logic              halt_req,
  output logic              demo_rom_en,
  output logic [PIN_W:0]    pin_out,
  input  logic [DATA_W-1:0] pin_data_in,
  output logic [DATA_W-1:0] pin_data_out,
  output logic              pin_data_oe
);
  logic              win_hit;
  logic [DATA_W-1:0] win_rd;
  logic [PIN_W-1:0]  view;
  logic              ext_we;
  logic              unused_cfg;
  view_sel_e         sel;

  assign unused_cfg = ^test_cfg[6:5];
  assign sel = view_sel_e'(test_cfg[2:0]);

  regwin_bank #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .REG_COUNT(REG_COUNT), .WIN_BASE(WIN_BASE)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .win_en(test_cfg[CFG_WIN_EN_BIT]),
    .addr(core_addr), .wdata(core_wdata), .we(core_we),
    .hit(win_hit), .rd_val(win_rd)
  );

  dbg_view_mux #(.DATA_W(DATA_W), .PIN_W(PIN_W)) u_view (
    .sel(sel), .bus_addr(core_addr[PIN_W-1:0]), .acc(dbg_acc),
    .mptr(dbg_mptr), .pc(dbg_pc), .ir(dbg_ir), .ccr(dbg_ccr),
    .cu_state(dbg_cu_state), .view(view)
  );

  assign ext_we       = core_we && !win_hit;
  assign pin_out      = {ext_we, view};
  assign pin_data_out = core_wdata;
  assign pin_data_oe  = ext_we;
  assign core_rdata   = win_hit ? win_rd : pin_data_in;
  assign halt_req     = test_cfg[CFG_HALT_BIT];
  assign demo_rom_en  = test_cfg[CFG_DEMO_BIT];

  // R3: a window write never strobes the pins
  a_r3_no_pin_we_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (core_we && win_hit) |-> !pin_out[PIN_W]);

  // R5: a disabled window never claims an access
  a_r5_off_never_hits: assert property (@(posedge clk) disable iff (!rst_n)
    !test_cfg[CFG_WIN_EN_BIT] |-> !win_hit);

  // R7: normal view shows the bus address
  a_r7_normal_view: assert property (@(posedge clk) disable iff (!rst_n)
    (test_cfg[2:0] == 3'd0) |-> (pin_out[PIN_W-1:0] == core_addr[PIN_W-1:0]));

  // R4: outside the window read data is the pin data
  a_r4_ext_read_path: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit |-> (core_rdata == pin_data_in));

endmodule

// File: tb/dbg_regwin_wrap_bench.sv
module dbg_regwin_wrap_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0] sel;
    logic [7:0] acc;
    logic [6:0] mptr;
    logic [6:0] pc;
    logic [6:0] ir;
    logic [1:0] ccr;
    logic [6:0] cu;
    logic [7:0] addr;
    logic [6:0] exp_pins;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{3'd0, 8'hA5, 7'h3C, 7'h11, 7'h5E, 2'b10, 7'h2B, 8'hC7, 7'h47},
    '{3'd1, 8'hA5, 7'h3C, 7'h11, 7'h5E, 2'b10, 7'h2B, 8'hC7, 7'h25},
    '{3'd2, 8'hA5, 7'h3C, 7'h11, 7'h5E, 2'b10, 7'h2B, 8'hC7, 7'h01},
    '{3'd3, 8'hA5, 7'h3C, 7'h11, 7'h5E, 2'b10, 7'h2B, 8'hC7, 7'h3C},
    '{3'd4, 8'hA5, 7'h3C, 7'h11, 7'h5E, 2'b10, 7'h2B, 8'hC7, 7'h11},
    '{3'd5, 8'hA5, 7'h3C, 7'h11, 7'h5E, 2'b10, 7'h2B, 8'hC7, 7'h5E},
    '{3'd6, 8'hA5, 7'h3C, 7'h11, 7'h5E, 2'b10, 7'h2B, 8'hC7, 7'h02},
    '{3'd7, 8'hA5, 7'h3C, 7'h11, 7'h5E, 2'b10, 7'h2B, 8'hC7, 7'h2B},
    '{3'd0, 8'h7F, 7'h41, 7'h62, 7'h13, 2'b01, 7'h55, 8'h78, 7'h78},
    '{3'd1, 8'h7F, 7'h41, 7'h62, 7'h13, 2'b01, 7'h55, 8'h78, 7'h7F},
    '{3'd2, 8'h7F, 7'h41, 7'h62, 7'h13, 2'b01, 7'h55, 8'h78, 7'h00},
    '{3'd3, 8'h7F, 7'h41, 7'h62, 7'h13, 2'b01, 7'h55, 8'h78, 7'h41},
    '{3'd4, 8'h7F, 7'h41, 7'h62, 7'h13, 2'b01, 7'h55, 8'h78, 7'h62},
    '{3'd5, 8'h7F, 7'h41, 7'h62, 7'h13, 2'b01, 7'h55, 8'h78, 7'h13},
    '{3'd6, 8'h7F, 7'h41, 7'h62, 7'h13, 2'b01, 7'h55, 8'h78, 7'h01},
    '{3'd7, 8'h7F, 7'h41, 7'h62, 7'h13, 2'b01, 7'h55, 8'h78, 7'h55}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] test_cfg = '0;
  logic [7:0] core_addr = '0;
  logic [7:0] core_wdata = '0;
  logic       core_we = 1'b0;
  logic [7:0] core_rdata;
  logic [7:0] dbg_acc = '0;
  logic [6:0] dbg_mptr = '0, dbg_pc = '0, dbg_ir = '0, dbg_cu_state = '0;
  logic [1:0] dbg_ccr = '0;
  logic       halt_req, demo_rom_en, pin_data_oe;
  logic [7:0] pin_out, pin_data_in = '0, pin_data_out;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_regwin_wrap u_dbg_regwin_wrap (
    .clk(clk), .rst_n(rst_n), .test_cfg(test_cfg),
    .core_addr(core_addr), .core_wdata(core_wdata), .core_we(core_we),
    .core_rdata(core_rdata), .dbg_acc(dbg_acc), .dbg_mptr(dbg_mptr),
    .dbg_pc(dbg_pc), .dbg_ir(dbg_ir), .dbg_ccr(dbg_ccr),
    .dbg_cu_state(dbg_cu_state), .halt_req(halt_req),
    .demo_rom_en(demo_rom_en), .pin_out(pin_out),
    .pin_data_in(pin_data_in), .pin_data_out(pin_data_out),
    .pin_data_oe(pin_data_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // drive at the falling edge, then settle before sampling
  task automatic drive(input logic [7:0] cfg, input logic [7:0] a,
                       input logic [7:0] wd, input logic we);
    @(negedge clk);
    test_cfg = cfg; core_addr = a; core_wdata = wd; core_we = we;
    #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: every register reads zero after reset
    for (int k = 0; k < 8; k++) begin
      drive(8'h80, 8'h78 + 8'(k), 8'h00, 1'b0);
      check("R1 reset value", core_rdata, 8'h00);
    end

    // R7 R8 R9: debug view table walk
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      dbg_acc = VECS[i].acc; dbg_mptr = VECS[i].mptr; dbg_pc = VECS[i].pc;
      dbg_ir = VECS[i].ir; dbg_ccr = VECS[i].ccr; dbg_cu_state = VECS[i].cu;
      core_addr = VECS[i].addr; core_we = 1'b0;
      test_cfg = {5'b00000, VECS[i].sel};
      #1;
      check("R7/R8/R9 debug view", {1'b0, pin_out[6:0]}, {1'b0, VECS[i].exp_pins});
    end

    // R2 R3: write every register; pin strobe stays low
    pin_data_in = 8'hC3;
    for (int k = 0; k < 8; k++) begin
      drive(8'h80, 8'h78 + 8'(k), 8'hD0 + 8'(k), 1'b1);
      check("R3 window write strobe", {7'b0, pin_out[7]}, 8'h00);
      check("R3 window write oe", {7'b0, pin_data_oe}, 8'h00);
    end
    // R2 R4: read back in the same cycle the address is presented
    for (int k = 0; k < 8; k++) begin
      drive(8'h80, 8'h78 + 8'(k), 8'h00, 1'b0);
      check("R2/R4 window read", core_rdata, 8'hD0 + 8'(k));
    end

    // R4: external read passes pin data
    pin_data_in = 8'h5A;
    drive(8'h80, 8'h40, 8'h00, 1'b0);
    check("R4 external read", core_rdata, 8'h5A);

    // R3 R11: external write strobes with a debug view selected
    drive(8'h81, 8'h40, 8'h9E, 1'b1);
    check("R11 strobe under debug view", {7'b0, pin_out[7]}, 8'h01);
    check("R3 external write data", pin_data_out, 8'h9E);
    check("R3 external oe", {7'b0, pin_data_oe}, 8'h01);

    // R5: window disabled, 0x7A goes external, register kept
    pin_data_in = 8'h33;
    drive(8'h00, 8'h7A, 8'hEE, 1'b1);
    check("R5 disabled write strobe", {7'b0, pin_out[7]}, 8'h01);
    drive(8'h00, 8'h7A, 8'h00, 1'b0);
    check("R5 disabled read", core_rdata, 8'h33);
    drive(8'h80, 8'h7A, 8'h00, 1'b0);
    check("R5 register untouched", core_rdata, 8'hD2);

    // R6: edges of the window
    drive(8'h80, 8'h77, 8'h00, 1'b0);
    check("R6 below window read", core_rdata, 8'h33);
    drive(8'h80, 8'hFB, 8'h00, 1'b0);
    check("R6 high alias read", core_rdata, 8'h33);
    drive(8'h80, 8'hFB, 8'h44, 1'b1);
    check("R6 high alias strobe", {7'b0, pin_out[7]}, 8'h01);
    drive(8'h80, 8'h7B, 8'h00, 1'b0);
    check("R6 register untouched", core_rdata, 8'hD3);

    // R10: pass-through bits and unused bits
    drive(8'h08, 8'h15, 8'h00, 1'b0);
    check("R10 halt", {6'b0, demo_rom_en, halt_req}, 8'h01);
    drive(8'h10, 8'h15, 8'h00, 1'b0);
    check("R10 demo enable", {6'b0, demo_rom_en, halt_req}, 8'h02);
    drive(8'h60, 8'h15, 8'h00, 1'b0);
    check("R10 unused bits outputs", {5'b0, demo_rom_en, halt_req, pin_data_oe}, 8'h00);
    check("R10 unused bits pins", pin_out, 8'h15);

    // R1: a second reset clears the bank again
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    drive(8'h80, 8'h7F, 8'h00, 1'b0);
    check("R1 re-reset value", core_rdata, 8'h00);

    done = 1;
    finish_run();
  end

endmodule